// File: doc/BRIEF.md
# Memory ECC Error Capture and Injection Registers

This block sits next to a 64-bit ECC-protected memory datapath and records what goes wrong on it. The datapath reports each corrected (single-bit) or uncorrectable (multi-bit) error with a one-cycle pulse. With each pulse it supplies the failing address, the 64 read data bits and the check/syndrome bits. The block keeps sticky detect flags, counts corrected errors against a programmable threshold and holds an interrupt line high while an enabled flag is set. It stores the first failing access in capture registers until software clears the flags.

On the write path, three injection registers can flip selected data bits and check bits of outgoing words, so that the error handling can be exercised. Software reaches all registers through a simple 32-bit register bus: a write strobe, a 4-bit word index, write data and a combinational read data return.

A two-state machine governs capture. In ST_ARMED no flag is set and any enabled error loads the capture registers. The ARM_TO_HELD transition fires when an error sets a flag. In ST_HELD the captured contents are frozen. The HELD_TO_ARM transition fires when software has cleared every flag.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset every register reads 0, `irq` is low and the write path passes data and check bits through unchanged. Register indices: 0 status, 1 interrupt enable, 2 detect mask, 3 corrected-error control, 4 captured data high, 5 captured data low, 6 captured syndrome, 7 captured address low, 8 captured address high, 9 inject data high, 10 inject data low, 11 inject control, 12 configuration. Unmapped indices read 0.
- R2: An `err_mbe` pulse sets status bit 1 at the next clock edge.
- R3: Register 3 holds the threshold in bits 23:16 and the running count (read-only) in bits 7:0. Each enabled `err_sbe` pulse advances the count. The pulse that brings the count to the threshold sets status bit 0 and returns the count to 0. A threshold of 0 acts as 1.
- R4: Writing register 0 clears each status bit whose write-data bit is 1, so 0xFFFFFFFF clears all of them. A flag set by an error in the same cycle as its clear stays set.
- R5: `irq` is high exactly while some status bit is set whose enable bit is set in register 1 (bit 0 corrected, bit 1 uncorrectable).
- R6: Capture registers load only on an enabled error that arrives while no status bit is set. They then hold until all flags are cleared.
- R7: A capture stores data bits 63:32 and 31:0, address bits 31:0, and the upper address bits zero-extended. With configuration bit 0 clear (64-bit bus) it stores the low 8 check bits zero-extended. With configuration bit 0 set (32-bit bus) it stores all 16 check bits.
- R8: Register 2 bit 0 masks corrected errors and bit 1 masks uncorrectable errors. A masked error changes no flag, no count and no capture. Writing 0 enables every source.
- R9: Registers 9, 10 and 11 read back what was written (register 11: bits 7:0 check mask, bit 8 enable). Only while bit 8 is set are the data masks XORed into `wr_data_out` and the check mask into `wr_chk_out`.
- R10: The capture machine is in ST_ARMED exactly when no status bit is set, and in ST_HELD otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| err_sbe | input | 1 | Corrected-error pulse |
| err_mbe | input | 1 | Uncorrectable-error pulse |
| err_addr | input | ADDR_W | Failing address |
| err_data | input | 64 | Read data of failing access |
| err_chk | input | 2*ECC_W | Check/syndrome bits of failing access |
| wr_data_in | input | 64 | Outgoing write data |
| wr_chk_in | input | ECC_W | Outgoing check bits |
| wr_data_out | output | 64 | Write data after injection |
| wr_chk_out | output | ECC_W | Check bits after injection |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is an error arriving in the same cycle as a partial status clear, while the threshold counter sits one below its limit and a flag from earlier still freezes the capture registers. Set-versus-clear priority, wrap of the count and the capture hold all meet there. The random phase issues clears, mask writes, threshold rewrites and error pulses together, biased toward small thresholds, so the count often hits its limit in the same cycle as a clear. Directed sequences cover threshold 0, the narrow syndrome and the capture hold before and after a full clear.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

    localparam int IDX_W    = 4;
    localparam int THR_W    = 8;
    localparam int THR_LSB  = 16;
    localparam int FLAG_SBE = 0;
    localparam int FLAG_MBE = 1;

    typedef enum logic [IDX_W-1:0] {
        RG_STATUS  = 4'd0,
        RG_IRQEN   = 4'd1,
        RG_MASK    = 4'd2,
        RG_SBECTL  = 4'd3,
        RG_CAP_DHI = 4'd4,
        RG_CAP_DLO = 4'd5,
        RG_CAP_SYN = 4'd6,
        RG_CAP_ALO = 4'd7,
        RG_CAP_AHI = 4'd8,
        RG_INJ_DHI = 4'd9,
        RG_INJ_DLO = 4'd10,
        RG_INJ_CTL = 4'd11,
        RG_CFG     = 4'd12
    } reg_idx_e;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_HELD  = 1'b1
    } cap_state_e;

endpackage

// File: rtl/ecc_sbe_counter.sv
module ecc_sbe_counter #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sbe_evt,
    input  logic [THR_W-1:0] thr,
    output logic [THR_W-1:0] count,
    output logic             hit
);
    logic [THR_W-1:0] cnt_q;
    logic [THR_W:0]   cnt_inc;
    logic [THR_W:0]   thr_eff;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign thr_eff = (thr == '0) ? {{THR_W{1'b0}}, 1'b1} : {1'b0, thr};
    assign hit     = sbe_evt && (cnt_inc >= thr_eff);
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (hit)     cnt_q <= '0;
        else if (sbe_evt) cnt_q <= cnt_inc[THR_W-1:0];
    end
endmodule

// File: rtl/ecc_cap_fsm.sv
module ecc_cap_fsm
    import ecc_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       any_err,
    input  logic       set_sbe,
    input  logic       set_mbe,
    input  logic       clr_wr,
    input  logic [1:0] clr_bits,
    output logic [1:0] flags,
    output cap_state_e state,
    output logic       cap_en
);
    cap_state_e state_q, state_d;
    logic [1:0] flags_q, flags_d;

    assign flags_d = (flags_q & ~(clr_wr ? clr_bits : 2'b00)) | {set_mbe, set_sbe};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (set_sbe || set_mbe) state_d = ST_HELD;
            ST_HELD:  if (flags_d == 2'b00)   state_d = ST_ARMED;
            default:  state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            flags_q <= 2'b00;
        end else begin
            state_q <= state_d;
            flags_q <= flags_d;
        end
    end

    always_comb begin
        cap_en = (state_q == ST_ARMED) && any_err;
        flags  = flags_q;
        state  = state_q;
    end
endmodule

// File: rtl/ecc_inject.sv
module ecc_inject #(
    parameter int DATA_W = 64,
    parameter int ECC_W  = 8
) (
    input  logic              enable,
    input  logic [DATA_W-1:0] data_in,
    input  logic [ECC_W-1:0]  chk_in,
    input  logic [DATA_W-1:0] data_mask,
    input  logic [ECC_W-1:0]  chk_mask,
    output logic [DATA_W-1:0] data_out,
    output logic [ECC_W-1:0]  chk_out
);
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_dbit
            assign data_out[gi] = data_in[gi] ^ (enable & data_mask[gi]);
        end
        for (gi = 0; gi < ECC_W; gi++) begin : g_cbit
            assign chk_out[gi] = chk_in[gi] ^ (enable & chk_mask[gi]);
        end
    endgenerate
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int ECC_W  = 8,
    localparam int SYN_W = 2 * ECC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [IDX_W-1:0]  reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              err_sbe,
    input  logic              err_mbe,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [63:0]       err_data,
    input  logic [SYN_W-1:0]  err_chk,
    input  logic [63:0]       wr_data_in,
    input  logic [ECC_W-1:0]  wr_chk_in,
    output logic [63:0]       wr_data_out,
    output logic [ECC_W-1:0]  wr_chk_out,
    output logic              irq
);
    logic [1:0]       irq_en_q, mask_q;
    logic [THR_W-1:0] thr_q, sbe_count;
    logic             narrow_q, inj_en_q;
    logic [31:0]      cap_dhi_q, cap_dlo_q, cap_alo_q, cap_ahi_q;
    logic [SYN_W-1:0] cap_syn_q, syn_sel;
    logic [31:0]      inj_dhi_q, inj_dlo_q, addr_hi_ext;
    logic [ECC_W-1:0] inj_ecc_q;
    logic [1:0]       flags;
    logic             q_sbe, q_mbe, sbe_hit, cap_en, clr_wr;
    cap_state_e       cap_state;

    assign q_sbe  = err_sbe && !mask_q[FLAG_SBE];
    assign q_mbe  = err_mbe && !mask_q[FLAG_MBE];
    assign clr_wr = reg_wen && (reg_addr == RG_STATUS);

    generate
        if (ADDR_W > 32) begin : g_ahi
            assign addr_hi_ext = 32'(err_addr[ADDR_W-1:32]);
        end else begin : g_no_ahi
            assign addr_hi_ext = '0;
        end
    endgenerate

    assign syn_sel = narrow_q ? err_chk : {{ECC_W{1'b0}}, err_chk[ECC_W-1:0]};

    ecc_sbe_counter #(.THR_W(THR_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .sbe_evt(q_sbe), .thr(thr_q),
        .count(sbe_count), .hit(sbe_hit)
    );

    ecc_cap_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .any_err(q_sbe || q_mbe),
        .set_sbe(sbe_hit), .set_mbe(q_mbe), .clr_wr(clr_wr),
        .clr_bits(reg_wdata[1:0]), .flags(flags), .state(cap_state),
        .cap_en(cap_en)
    );

    ecc_inject #(.DATA_W(64), .ECC_W(ECC_W)) u_inj (
        .enable(inj_en_q), .data_in(wr_data_in), .chk_in(wr_chk_in),
        .data_mask({inj_dhi_q, inj_dlo_q}), .chk_mask(inj_ecc_q),
        .data_out(wr_data_out), .chk_out(wr_chk_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q  <= '0;
            mask_q    <= '0;
            thr_q     <= '0;
            narrow_q  <= 1'b0;
            inj_en_q  <= 1'b0;
            inj_ecc_q <= '0;
            inj_dhi_q <= '0;
            inj_dlo_q <= '0;
        end else if (reg_wen) begin
            case (reg_addr)
                RG_IRQEN:   irq_en_q  <= reg_wdata[1:0];
                RG_MASK:    mask_q    <= reg_wdata[1:0];
                RG_SBECTL:  thr_q     <= reg_wdata[THR_LSB +: THR_W];
                RG_CFG:     narrow_q  <= reg_wdata[0];
                RG_INJ_DHI: inj_dhi_q <= reg_wdata;
                RG_INJ_DLO: inj_dlo_q <= reg_wdata;
                RG_INJ_CTL: begin
                    inj_ecc_q <= reg_wdata[ECC_W-1:0];
                    inj_en_q  <= reg_wdata[ECC_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_dhi_q <= '0;
            cap_dlo_q <= '0;
            cap_alo_q <= '0;
            cap_ahi_q <= '0;
            cap_syn_q <= '0;
        end else if (cap_en) begin
            cap_dhi_q <= err_data[63:32];
            cap_dlo_q <= err_data[31:0];
            cap_alo_q <= err_addr[31:0];
            cap_ahi_q <= addr_hi_ext;
            cap_syn_q <= syn_sel;
        end
    end

    assign irq = |(flags & irq_en_q);

    always_comb begin
        case (reg_addr)
            RG_STATUS:  reg_rdata = {30'b0, flags};
            RG_IRQEN:   reg_rdata = {30'b0, irq_en_q};
            RG_MASK:    reg_rdata = {30'b0, mask_q};
            RG_SBECTL:  reg_rdata = {8'b0, thr_q, 8'b0, sbe_count};
            RG_CAP_DHI: reg_rdata = cap_dhi_q;
            RG_CAP_DLO: reg_rdata = cap_dlo_q;
            RG_CAP_SYN: reg_rdata = {{(32-SYN_W){1'b0}}, cap_syn_q};
            RG_CAP_ALO: reg_rdata = cap_alo_q;
            RG_CAP_AHI: reg_rdata = cap_ahi_q;
            RG_INJ_DHI: reg_rdata = inj_dhi_q;
            RG_INJ_DLO: reg_rdata = inj_dlo_q;
            RG_INJ_CTL: reg_rdata = {{(31-ECC_W){1'b0}}, inj_en_q, inj_ecc_q};
            RG_CFG:     reg_rdata = {31'b0, narrow_q};
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk
    import ecc_cap_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        err_mbe,
    input logic [1:0]  mask_q,
    input logic [1:0]  flags,
    input logic [1:0]  irq_en_q,
    input logic        irq,
    input logic        sbe_hit,
    input logic [7:0]  sbe_count,
    input logic        clr_wr,
    input logic [31:0] cap_dlo_q,
    input logic [31:0] cap_dhi_q,
    input logic        inj_en_q,
    input logic [63:0] wr_data_in,
    input logic [63:0] wr_data_out,
    input cap_state_e  cap_state
);
    AST_MBE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (err_mbe && !mask_q[1]) |=> flags[1]); // R2

    AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        sbe_hit |=> (sbe_count == 8'd0) && flags[0]); // R3

    AST_CLEAR_WINS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 2'b00 && !sbe_hit && !(err_mbe && !mask_q[1])) |=> flags == 2'b00); // R4

    AST_IRQ_OFF_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_q == 2'b00) |-> !irq); // R5

    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (flags != 2'b00) |=> ($stable(cap_dlo_q) && $stable(cap_dhi_q))); // R6

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 2'b11 && flags == 2'b00 && !clr_wr) |=> flags == 2'b00); // R8

    AST_INJ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_en_q |-> (wr_data_out == wr_data_in)); // R9

    AST_STATE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == ST_ARMED) == (flags == 2'b00)); // R10
endmodule

bind ecc_err_capture ecc_err_capture_chk u_chk (
    .clk(clk), .rst_n(rst_n), .err_mbe(err_mbe), .mask_q(mask_q),
    .flags(flags), .irq_en_q(irq_en_q), .irq(irq), .sbe_hit(sbe_hit),
    .sbe_count(sbe_count), .clr_wr(clr_wr), .cap_dlo_q(cap_dlo_q),
    .cap_dhi_q(cap_dhi_q), .inj_en_q(inj_en_q), .wr_data_in(wr_data_in),
    .wr_data_out(wr_data_out), .cap_state(cap_state)
);

// File: tb/ecc_err_capture_bench.sv
`timescale 1ns/1ps
module ecc_err_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        err_sbe = 1'b0, err_mbe = 1'b0;
    logic [39:0] err_addr = '0;
    logic [63:0] err_data = '0;
    logic [15:0] err_chk = '0;
    logic [63:0] wr_data_in = '0, wr_data_out;
    logic [7:0]  wr_chk_in = '0, wr_chk_out;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    logic [1:0]  m_flags = 0, m_en = 0, m_mask = 0;
    logic [7:0]  m_cnt = 0, m_thr = 0;
    logic        m_narrow = 0;
    logic [31:0] m_dhi = 0, m_dlo = 0, m_alo = 0, m_ahi = 0, m_syn = 0;

    always #2.5 clk = ~clk;

    ecc_err_capture u_ecc_err_capture (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic step(bit s, bit m, bit w, logic [3:0] a, logic [31:0] d,
                        logic [63:0] dat, logic [39:0] adr, logic [15:0] ck);
        bit qs, qm;
        logic [1:0] sets;
        int eff;
        @(negedge clk);
        err_sbe = s; err_mbe = m; reg_wen = w; reg_addr = a; reg_wdata = d;
        err_data = dat; err_addr = adr; err_chk = ck;
        @(posedge clk);
        qs = s && !m_mask[0];
        qm = m && !m_mask[1];
        if ((qs || qm) && m_flags == 2'b00) begin
            m_dhi = dat[63:32]; m_dlo = dat[31:0];
            m_alo = adr[31:0];  m_ahi = {24'h0, adr[39:32]};
            m_syn = m_narrow ? {16'h0, ck} : {24'h0, ck[7:0]};
        end
        sets = 2'b00;
        if (qs) begin
            eff = (m_thr == 0) ? 1 : int'(m_thr);
            if (int'(m_cnt) + 1 >= eff) begin m_cnt = 0; sets[0] = 1'b1; end
            else m_cnt = m_cnt + 1;
        end
        if (qm) sets[1] = 1'b1;
        if (w && a == 4'd0) m_flags = m_flags & ~d[1:0];
        m_flags = m_flags | sets;
        if (w) begin
            case (a)
                4'd1:  m_en = d[1:0];
                4'd2:  m_mask = d[1:0];
                4'd3:  m_thr = d[23:16];
                4'd12: m_narrow = d[0];
                default: ;
            endcase
        end
        #1;
        err_sbe = 0; err_mbe = 0; reg_wen = 0;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        step(0, 0, 1, a, d, '0, '0, '0);
    endtask

    task automatic check_state(string tag);
        rd(4'd0, {30'b0, m_flags}, {tag, " R4 status"});
        rd(4'd3, {8'b0, m_thr, 8'b0, m_cnt}, {tag, " R3 sbectl"});
        chk({tag, " R5 irq"}, irq, |(m_flags & m_en));
    endtask

    task automatic check_caps(string tag);
        rd(4'd4, m_dhi, {tag, " R7 cap dhi"});
        rd(4'd5, m_dlo, {tag, " R7 cap dlo"});
        rd(4'd6, m_syn, {tag, " R7 cap syn"});
        rd(4'd7, m_alo, {tag, " R7 cap alo"});
        rd(4'd8, m_ahi, {tag, " R7 cap ahi"});
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int i = 0; i < 16; i++) rd(i[3:0], 32'h0, "R1 reset read");
        chk("R1 irq low", irq, 1'b0);
        wr_data_in = 64'h1234_5678_9abc_def0; wr_chk_in = 8'h5a; #0.5;
        chk("R1 passthrough data", wr_data_out, wr_data_in);
        chk("R1 passthrough chk", wr_chk_out, 8'h5a);

        wr(4'd1, 32'h3);
        // R2 MBE and R7 capture, 64-bit mode
        step(0, 1, 0, 0, 0, 64'hAAAA_0001_BBBB_0002, 40'hC5_1111_2222, 16'hF00D);
        check_state("R2 mbe"); check_caps("R2");
        chk("R10 held irq", irq, 1'b1);
        // R6 second error does not overwrite
        step(1, 0, 0, 0, 0, 64'h0, 40'h0, 16'h0);
        check_caps("R6 hold");
        // R4 partial then full clear
        wr(4'd0, 32'h1); check_state("R4 partial");
        wr(4'd0, 32'hFFFF_FFFF); check_state("R4 full");
        // R7 narrow syndrome
        wr(4'd12, 32'h1);
        step(0, 1, 0, 0, 0, 64'h5555_6666_7777_8888, 40'h01_0000_0004, 16'hBEEF);
        check_caps("R7 narrow");
        // R4 clear in same cycle as set: set wins
        step(0, 1, 1, 4'd0, 32'h2, 64'h1, 40'h0, 16'h0);
        check_state("R4 set wins");
        wr(4'd0, 32'hFFFF_FFFF);
        // R3 threshold 3
        wr(4'd3, 32'h0003_0000);
        for (int i = 0; i < 3; i++) begin
            step(1, 0, 0, 0, 0, 64'(i), 40'h0, 16'h0);
            check_state("R3 thr3");
        end
        wr(4'd0, 32'hFFFF_FFFF);
        // R3 threshold 0 acts as 1
        wr(4'd3, 32'h0);
        step(1, 0, 0, 0, 0, 64'h9, 40'h0, 16'h0);
        check_state("R3 thr0");
        wr(4'd0, 32'hFFFF_FFFF);
        // R8 masked errors
        wr(4'd2, 32'h3);
        step(1, 1, 0, 0, 0, 64'hDEAD, 40'h7, 16'h7);
        check_state("R8 masked"); check_caps("R8 masked");
        wr(4'd2, 32'h0);
        // R5 enable subset
        wr(4'd1, 32'h1);
        step(0, 1, 0, 0, 0, 64'h3, 40'h3, 16'h3);
        check_state("R5 mbe not enabled");
        wr(4'd1, 32'h3); wr(4'd0, 32'hFFFF_FFFF);
        // R9 injection
        wr(4'd9, 32'h8000_0001); wr(4'd10, 32'h0000_0100); wr(4'd11, 32'h0000_00A5);
        rd(4'd9, 32'h8000_0001, "R9 readback hi");
        rd(4'd10, 32'h0000_0100, "R9 readback lo");
        rd(4'd11, 32'h0000_00A5, "R9 readback ctl");
        chk("R9 disabled data", wr_data_out, wr_data_in);
        chk("R9 disabled chk", wr_chk_out, wr_chk_in);
        wr(4'd11, 32'h0000_01A5); #0.5;
        chk("R9 enabled data", wr_data_out, wr_data_in ^ 64'h8000_0001_0000_0100);
        chk("R9 enabled chk", wr_chk_out, wr_chk_in ^ 8'hA5);

        // random phase: R2 R3 R4 R6 R8
        for (int it = 0; it < 600; it++) begin
            int k;
            logic [63:0] dat;
            logic [39:0] adr;
            logic [15:0] ck;
            k = $urandom % 10;
            dat = {$urandom, $urandom};
            adr = {8'($urandom), 32'($urandom)};
            ck = 16'($urandom);
            case (k)
                0, 1, 2, 3: step(1, 0, 0, 0, 0, dat, adr, ck);
                4:          step(0, 1, 0, 0, 0, dat, adr, ck);
                5:          step(1, 1, 0, 0, 0, dat, adr, ck);
                6:          step($urandom % 2, $urandom % 2, 1, 4'd0, $urandom, dat, adr, ck);
                7:          wr(4'd2, ($urandom % 3 == 0) ? 32'($urandom % 4) : 32'h0);
                8:          wr(4'd3, {8'h0, 8'($urandom % 5), 16'h0});
                default:    step(0, 0, 0, 0, 0, dat, adr, ck);
            endcase
            check_state("rand");
            if (it % 4 == 0) check_caps("rand R6");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule